// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is the host side of the two-wire serial management bus that configures and monitors Ethernet PHYs. Software sets up a small bank of registers: a clock divider with a preamble-suppress option, a PHY address and register number, and 16 bits of outgoing data. It then raises a command bit to run one write, one read, or a continuous scan. The block produces the management clock and drives the data line through a separate output enable. It releases the line so the PHY can answer read data, and it captures the returned 16 bits.

Scan mode polls the PHY status register again and again while the scan bit stays set. It keeps a link-fail flag current and raises an invalid flag until the first poll has completed. Command bits are levels held by software. A finished command does not repeat until software has cleared the command register and set a bit again. Reads of the register port return data one clock after the address is presented.

Top module: `mdio_master`

## Requirements
- R1: After reset every readable register returns 0, the management clock is low and the output enable is low.
- R2: Registers sit at word offsets 0 (mode), 1 (command), 2 (address), 3 (transmit data), 4 (receive data) and 5 (status), and read data appears one clock after the address. Mode keeps the divider in bits 7:0 and preamble suppress in bit 8. Address keeps the PHY address in bits 4:0 and the register number in bits 12:8. The data registers keep bits 15:0 only, and other bits read as 0.
- R3: One management clock period lasts the divider value with bit 0 forced to 0, in system clocks. A result below 2 is raised to 2.
- R4: Each frame opens with 32 one-bits of preamble, unless mode bit 8 is set, in which case it opens directly with the start bits.
- R5: A write frame sends start 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10 and the 16 data bits, each MSB first. The data line changes only while the clock falls, never when it rises.
- R6: A read frame sends start 01, opcode 10, the PHY address and the register number. It then turns the output enable off for the turnaround and the 16 data bits, samples the line on each clock rise, and places the 16 bits in the receive data register when the frame ends.
- R7: Status bit 1 (busy) rises when a command is accepted and stays high until the transaction is complete.
- R8: A command is accepted only when the block is idle and the command register has been all zero since the last accepted command. A bit left set after completion starts nothing.
- R9: When several command bits (bit 2 write, bit 1 read, bit 0 scan) are set together, write takes precedence over read, and read over scan.
- R10: Scan reads PHY register 1 back to back while command bit 0 stays set. Status bit 0 (link fail) becomes the inverse of bit 2 of each result. Status bit 2 (invalid) is set from scan start until the first scan read completes. Clearing bit 0 ends the scan after the current frame.
- R11: While busy is low, the management clock is low and the output enable is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register word offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, one clock after the address |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the block with its default parameters: an 8-bit divider, 5-bit PHY address and register fields, and 16-bit data. Because the divider is a software field, one build can step through periods of 2, 4 and 6 clocks, including the odd and zero divider cases, without changing any parameter. A behavioural PHY answers reads, and the scan test switches its returned status mid-scan so the link-fail flag moves in both directions. With the short divider, the preamble and suppressed-preamble frames, the held-command case and back-to-back scan frames all fit well inside the run.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int OFS_MODE = 0;
  localparam int OFS_CMD  = 1;
  localparam int OFS_ADDR = 2;
  localparam int OFS_TXD  = 3;
  localparam int OFS_RXD  = 4;
  localparam int OFS_STAT = 5;

  localparam int MODE_NOPRE_BIT  = 8;
  localparam int REGNUM_LSB      = 8;
  localparam int CMD_SCAN_BIT    = 0;
  localparam int CMD_READ_BIT    = 1;
  localparam int CMD_WRITE_BIT   = 2;
  localparam int ST_LINKFAIL_BIT = 0;
  localparam int ST_BUSY_BIT     = 1;
  localparam int ST_INVALID_BIT  = 2;

  localparam int PRE_LEN = 32;

  typedef enum logic [1:0] {SEL_NONE, SEL_WRITE, SEL_READ, SEL_SCAN} cmd_sel_e;

  function automatic cmd_sel_e pick_cmd(input logic [2:0] c);
    if (c[CMD_WRITE_BIT])     return SEL_WRITE;
    else if (c[CMD_READ_BIT]) return SEL_READ;
    else if (c[CMD_SCAN_BIT]) return SEL_SCAN;
    else                      return SEL_NONE;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] divider,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  localparam int HALF_W = DIV_W - 1;

  logic [HALF_W-1:0] half_eff;
  logic [HALF_W-1:0] cnt;
  logic              tick;

  always_comb begin
    half_eff = divider[DIV_W-1:1];
    if (half_eff == '0) half_eff = HALF_W'(1);
  end

  assign tick = run && (cnt >= half_eff - HALF_W'(1));
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PHY_W = 5,
  parameter int REG_W = 5,
  parameter int MD_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_read,
  input  logic             nopre,
  input  logic [PHY_W-1:0] phy,
  input  logic [REG_W-1:0] regn,
  input  logic [MD_W-1:0]  wdata,
  input  logic             rise,
  input  logic             fall,
  input  logic             mdio_i,
  output logic             active,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             done,
  output logic [MD_W-1:0]  rdata
);
  localparam int BODY_W   = 4 + PHY_W + REG_W + 2 + MD_W;
  localparam int TOTAL    = PRE_LEN + BODY_W;
  localparam int POS_W    = $clog2(TOTAL);
  localparam int TA_POS   = PRE_LEN + 4 + PHY_W + REG_W;
  localparam int DATA_POS = TA_POS + 2;

  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  nxt;
  logic [BODY_W-1:0] body;
  logic              rd_q;

  assign nxt = pos + POS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      pos     <= '0;
      body    <= '0;
      rd_q    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          rd_q    <= is_read;
          pos     <= nopre ? POS_W'(PRE_LEN) : '0;
          body    <= {2'b01, (is_read ? 2'b10 : 2'b01), phy, regn, 2'b10,
                      (is_read ? MD_W'(0) : wdata)};
          mdio_o  <= ~nopre;
          mdio_oe <= 1'b1;
        end
      end else if (fall) begin
        if (pos == POS_W'(TOTAL - 1)) begin
          active  <= 1'b0;
          mdio_o  <= 1'b0;
          mdio_oe <= 1'b0;
          done    <= 1'b1;
        end else begin
          pos <= nxt;
          if (pos >= POS_W'(PRE_LEN)) begin
            body   <= body << 1;
            mdio_o <= body[BODY_W-2];
          end else if (nxt == POS_W'(PRE_LEN)) begin
            mdio_o <= body[BODY_W-1];
          end else begin
            mdio_o <= 1'b1;
          end
          mdio_oe <= !(rd_q && (nxt >= POS_W'(TA_POS)));
        end
      end else if (rise && rd_q && (pos >= POS_W'(DATA_POS))) begin
        rdata <= {rdata[MD_W-2:0], mdio_i};
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32,
  parameter int DIV_W    = 8,
  parameter int PHY_W    = 5,
  parameter int REG_W    = 5,
  parameter int MD_W     = 16,
  parameter int SCAN_REG = 1,
  parameter int LINK_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DIV_W-1:0]  div_o,
  output logic              nopre_o,
  output logic              eng_start,
  output logic              eng_read,
  output logic [PHY_W-1:0]  eng_phy,
  output logic [REG_W-1:0]  eng_reg,
  output logic [MD_W-1:0]   eng_wdata,
  input  logic              eng_done,
  input  logic [MD_W-1:0]   eng_rdata,
  output logic              busy_o,
  output logic              invalid_o,
  output logic [2:0]        cmd_o
);
  logic [PHY_W-1:0]  phy_q;
  logic [REG_W-1:0]  reg_q;
  logic [MD_W-1:0]   tx_q;
  logic [MD_W-1:0]   rx_q;
  logic              linkfail_q;
  logic              scanning;
  logic              cmd_hold;
  cmd_sel_e          sel;
  logic              accept;
  logic [DATA_W-1:0] rd_mux;

  assign sel    = pick_cmd(cmd_o);
  assign accept = !busy_o && !cmd_hold && (sel != SEL_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_o      <= '0;
      nopre_o    <= 1'b0;
      cmd_o      <= '0;
      phy_q      <= '0;
      reg_q      <= '0;
      tx_q       <= '0;
      rx_q       <= '0;
      linkfail_q <= 1'b0;
      scanning   <= 1'b0;
      cmd_hold   <= 1'b0;
      busy_o     <= 1'b0;
      invalid_o  <= 1'b0;
      eng_start  <= 1'b0;
      eng_read   <= 1'b0;
      eng_phy    <= '0;
      eng_reg    <= '0;
      eng_wdata  <= '0;
    end else begin
      eng_start <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          ADDR_W'(OFS_MODE): begin
            div_o   <= reg_wdata[DIV_W-1:0];
            nopre_o <= reg_wdata[MODE_NOPRE_BIT];
          end
          ADDR_W'(OFS_CMD):  cmd_o <= reg_wdata[2:0];
          ADDR_W'(OFS_ADDR): begin
            phy_q <= reg_wdata[PHY_W-1:0];
            reg_q <= reg_wdata[REGNUM_LSB +: REG_W];
          end
          ADDR_W'(OFS_TXD):  tx_q <= reg_wdata[MD_W-1:0];
          default: ;
        endcase
      end

      if (accept)              cmd_hold <= 1'b1;
      else if (cmd_o == 3'b0)  cmd_hold <= 1'b0;

      if (accept) begin
        busy_o    <= 1'b1;
        eng_start <= 1'b1;
        eng_read  <= (sel != SEL_WRITE);
        eng_phy   <= phy_q;
        eng_reg   <= (sel == SEL_SCAN) ? REG_W'(SCAN_REG) : reg_q;
        eng_wdata <= tx_q;
        scanning  <= (sel == SEL_SCAN);
        invalid_o <= (sel == SEL_SCAN);
      end else if (eng_done) begin
        if (eng_read) rx_q <= eng_rdata;
        if (scanning) begin
          linkfail_q <= ~eng_rdata[LINK_BIT];
          invalid_o  <= 1'b0;
          if (cmd_o[CMD_SCAN_BIT]) begin
            eng_start <= 1'b1;
            eng_phy   <= phy_q;
          end else begin
            busy_o   <= 1'b0;
            scanning <= 1'b0;
          end
        end else begin
          busy_o <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(OFS_MODE): begin
        rd_mux[DIV_W-1:0]     = div_o;
        rd_mux[MODE_NOPRE_BIT] = nopre_o;
      end
      ADDR_W'(OFS_CMD):  rd_mux[2:0] = cmd_o;
      ADDR_W'(OFS_ADDR): begin
        rd_mux[PHY_W-1:0]            = phy_q;
        rd_mux[REGNUM_LSB +: REG_W]  = reg_q;
      end
      ADDR_W'(OFS_TXD):  rd_mux[MD_W-1:0] = tx_q;
      ADDR_W'(OFS_RXD):  rd_mux[MD_W-1:0] = rx_q;
      ADDR_W'(OFS_STAT): begin
        rd_mux[ST_LINKFAIL_BIT] = linkfail_q;
        rd_mux[ST_BUSY_BIT]     = busy_o;
        rd_mux[ST_INVALID_BIT]  = invalid_o;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int MD_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [DIV_W-1:0] div_w;
  logic             nopre_w;
  logic             start_w;
  logic             read_w;
  logic [PHY_W-1:0] eng_phy_w;
  logic [REG_W-1:0] eng_reg_w;
  logic [MD_W-1:0]  eng_wd_w;
  logic             done_w;
  logic [MD_W-1:0]  eng_rd_w;
  logic             busy_w;
  logic             invalid_w;
  logic [2:0]       cmd_w;
  logic             run_w;
  logic             rise_w;
  logic             fall_w;

  mdio_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
    .PHY_W(PHY_W), .REG_W(REG_W), .MD_W(MD_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .div_o(div_w), .nopre_o(nopre_w),
    .eng_start(start_w), .eng_read(read_w), .eng_phy(eng_phy_w), .eng_reg(eng_reg_w),
    .eng_wdata(eng_wd_w), .eng_done(done_w), .eng_rdata(eng_rd_w),
    .busy_o(busy_w), .invalid_o(invalid_w), .cmd_o(cmd_w)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(run_w), .divider(div_w),
    .mdc(mdc), .rise(rise_w), .fall(fall_w)
  );

  mdio_frame #(.PHY_W(PHY_W), .REG_W(REG_W), .MD_W(MD_W)) u_frame (
    .clk(clk), .rst(rst), .start(start_w), .is_read(read_w), .nopre(nopre_w),
    .phy(eng_phy_w), .regn(eng_reg_w), .wdata(eng_wd_w),
    .rise(rise_w), .fall(fall_w), .mdio_i(mdio_i),
    .active(run_w), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done_w), .rdata(eng_rd_w)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       busy,
  input logic       invalid,
  input logic [2:0] cmd_bits
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdio_oe && !mdc)); // R11

  AST_DATA_STILL_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R5

  AST_INVALID_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    invalid |-> busy); // R10

  AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(cmd_bits) != 3'b000)); // R7

  AST_MDC_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mdc |-> busy); // R11
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy_w), .invalid(invalid_w), .cmd_bits(cmd_w)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  typedef struct packed {
    logic [7:0]  pre;
    logic [7:0]  period;
    logic [1:0]  st;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [1:0]  ta;
    logic [15:0] data;
    logic        oe_bad;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_drive = 1'b1;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  item_t exp_q[$];
  string req_q[$];
  int    frames_seen = 0;
  int    scan_frames = 0;
  bit    scan_watch = 0;
  logic [4:0]  scan_phy = '0;
  logic [15:0] phy_val = '0;

  always #2 clk = ~clk;

  mdio_master u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(phy_drive)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    repeat (4) @(posedge clk);
    for (int i = 0; i < 20000; i++) begin
      rd(3'd5, v);
      if (!v[1]) break;
    end
  endtask

  function automatic item_t mk(input bit is_rd, input logic [4:0] phy, input logic [4:0] rg,
                               input logic [15:0] data, input int pre, input int per);
    item_t it;
    it.pre = 8'(pre); it.period = 8'(per); it.st = 2'b01;
    it.op = is_rd ? 2'b10 : 2'b01; it.phy = phy; it.rg = rg; it.ta = 2'b10;
    it.data = data; it.oe_bad = 1'b0;
    return it;
  endfunction

  // driver: push the expected frame, issue the command, check busy, wait for completion
  task automatic run_cmd(input logic [2:0] cmd, input item_t exp, input string req, input bit clear);
    logic [31:0] v;
    exp_q.push_back(exp);
    req_q.push_back(req);
    wr(3'd1, {29'b0, cmd});
    repeat (4) @(posedge clk);
    rd(3'd5, v);
    chk("R7 busy after accept", 64'(v[1]), 64'd1);
    wait_idle();
    if (clear) wr(3'd1, 32'd0);
  endtask

  // monitor: a behavioural PHY decoding frames
  int k = -1;
  int pre_cnt = 0;
  int per_m = 0;
  logic [31:0] f = '0;
  logic is_rd_m = 1'b0;
  logic oe_bad_m = 1'b0;
  longint t_prev = 0;

  always @(posedge mdc) begin
    logic b;
    item_t got, ex;
    string rq;
    if (k < 0) begin
      if (mdio_oe) begin
        if (mdio_o) pre_cnt++;
        else begin
          k = 0; f = '0; oe_bad_m = 1'b0; is_rd_m = 1'b0; t_prev = $time;
        end
      end
    end else begin
      k++;
      if (k == 1) per_m = int'(($time - t_prev) / 4);
      if (is_rd_m && k >= 14) begin
        if (mdio_oe) oe_bad_m = 1'b1;
        b = phy_drive;
      end else begin
        if (!mdio_oe) oe_bad_m = 1'b1;
        b = mdio_o;
      end
      f = {f[30:0], b};
      if (k == 3) is_rd_m = (f[1:0] == 2'b10);
      if (k == 31) begin
        got.pre = 8'(pre_cnt); got.period = 8'(per_m);
        got.st = f[31:30]; got.op = f[29:28]; got.phy = f[27:23]; got.rg = f[22:18];
        got.ta = f[17:16]; got.data = f[15:0]; got.oe_bad = oe_bad_m;
        frames_seen++;
        if (scan_watch) begin
          scan_frames++;
          chk("R10 scan frame header", 64'({got.st, got.op, got.phy, got.rg}),
              64'({2'b01, 2'b10, scan_phy, 5'd1}));
          chk("R6 scan oe released", 64'(got.oe_bad), 64'd0);
        end else if (exp_q.size() == 0) begin
          chk("R8 unexpected frame", 64'(got), 64'd0);
        end else begin
          ex = exp_q.pop_front();
          rq = req_q.pop_front();
          chk(rq, 64'(got), 64'(ex));
        end
        k = -1; pre_cnt = 0;
      end
    end
  end

  always @(negedge mdc) begin
    int nxt;
    nxt = k + 1;
    if (k >= 13 && k < 31 && is_rd_m)
      phy_drive = (nxt == 14) ? 1'b1 : (nxt == 15) ? 1'b0 : phy_val[31 - nxt];
    else
      phy_drive = 1'b1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 register reset value", 64'(v), 64'd0);
    end
    chk("R1 mdc and oe low", 64'({mdc, mdio_oe}), 64'd0);

    // R2 field storage
    wr(3'd0, 32'hFFFF_FF04); rd(3'd0, v); chk("R2 mode readback", 64'(v), 64'h104);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); chk("R2 address readback", 64'(v), 64'h1F1F);
    wr(3'd3, 32'hDEAD_BEEF); rd(3'd3, v); chk("R2 txdata readback", 64'(v), 64'hBEEF);

    // R4 R5 write frame with preamble, divider 4
    wr(3'd0, 32'h4);
    wr(3'd2, {19'b0, 5'h13, 3'b0, 5'h0A});
    wr(3'd3, 32'h0000_A5C3);
    run_cmd(3'b100, mk(0, 5'h0A, 5'h13, 16'hA5C3, 32, 4), "R4 R5 write frame", 1);

    // R6 read frame, preamble suppressed, divider 6
    wr(3'd0, 32'h106);
    wr(3'd2, {19'b0, 5'h02, 3'b0, 5'h03});
    phy_val = 16'h3C5A;
    run_cmd(3'b010, mk(1, 5'h03, 5'h02, 16'h3C5A, 0, 6), "R4 R6 read frame", 1);
    rd(3'd4, v); chk("R6 rxdata captured", 64'(v), 64'h3C5A);

    // R3 divider corner cases
    wr(3'd3, 32'h0000_0F0F);
    wr(3'd0, 32'h5);
    run_cmd(3'b100, mk(0, 5'h03, 5'h02, 16'h0F0F, 32, 4), "R3 odd divider 5", 1);
    wr(3'd0, 32'h0);
    run_cmd(3'b100, mk(0, 5'h03, 5'h02, 16'h0F0F, 32, 2), "R3 divider 0", 1);
    wr(3'd0, 32'h1);
    run_cmd(3'b100, mk(0, 5'h03, 5'h02, 16'h0F0F, 32, 2), "R3 divider 1", 1);

    // R8 level-held command does not repeat
    wr(3'd0, 32'h4);
    phy_val = 16'h1234;
    run_cmd(3'b010, mk(1, 5'h03, 5'h02, 16'h1234, 32, 4), "R8 first read", 0);
    n0 = frames_seen;
    repeat (600) @(posedge clk);
    chk("R8 no repeat while held", 64'(frames_seen), 64'(n0));
    rd(3'd5, v); chk("R8 idle while held", 64'(v[1]), 64'd0);
    wr(3'd1, 32'd0);
    phy_val = 16'h8001;
    run_cmd(3'b010, mk(1, 5'h03, 5'h02, 16'h8001, 32, 4), "R8 re-armed read", 1);
    rd(3'd4, v); chk("R6 rxdata second read", 64'(v), 64'h8001);

    // R9 priority
    wr(3'd3, 32'h0000_5AA5);
    run_cmd(3'b111, mk(0, 5'h03, 5'h02, 16'h5AA5, 32, 4), "R9 write wins", 1);
    phy_val = 16'h0C30;
    run_cmd(3'b011, mk(1, 5'h03, 5'h02, 16'h0C30, 32, 4), "R9 read over scan", 1);

    // R10 scan
    wr(3'd0, 32'h2);
    wr(3'd2, {19'b0, 5'h09, 3'b0, 5'h07});
    scan_phy = 5'h07;
    phy_val = 16'h0000;
    scan_watch = 1;
    wr(3'd1, 32'h1);
    repeat (4) @(posedge clk);
    rd(3'd5, v); chk("R10 invalid until first scan", 64'(v[2:0]), 64'h6);
    wait (scan_frames >= 1);
    repeat (20) @(posedge clk);
    rd(3'd5, v); chk("R10 link fail set", 64'(v[2:0]), 64'h3);
    phy_val = 16'h0004;
    n0 = scan_frames;
    wait (scan_frames >= n0 + 2);
    repeat (20) @(posedge clk);
    rd(3'd5, v); chk("R10 link fail cleared", 64'(v[2:0]), 64'h2);
    rd(3'd4, v); chk("R10 scan rxdata", 64'(v), 64'h0004);
    wr(3'd1, 32'd0);
    wait_idle();
    n0 = scan_frames;
    repeat (400) @(posedge clk);
    chk("R10 scan stops", 64'(scan_frames), 64'(n0));
    chk("R11 quiet when idle", 64'({mdc, mdio_oe}), 64'd0);
    scan_watch = 0;

    chk("R5 all expected frames seen", 64'(exp_q.size()), 64'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule